// File: doc/BRIEF.md
# CAN Controller Mode and Interrupt Register Bank

This block is the software-visible control face of a CAN controller. It sits on a 32-bit, word-addressed register bus. It turns processor writes into mode settings and one-cycle command strobes for the protocol engine. It also reflects the engine's live status back to the bus. Hardware event pulses from the engine are collected into sticky interrupt flags, and a single interrupt line is raised whenever an enabled flag is pending.

Operating mode is governed by a two-state machine. In `MODE_CFG` (the configuration hold, where the reset-mode bit reads 1) every mode bit is writable. In `MODE_RUN` (reset-mode bit 0) the filter-select and sleep bits are frozen. Two transitions are named:
- `GO_RUN` fires on a mode write with bit 0 clear while in `MODE_CFG`.
- `GO_CFG` fires on a mode write with bit 0 set while in `MODE_RUN`.

Reset enters `MODE_CFG`. The bit engine, the message buffers and the acceptance filters live elsewhere. They see this block only through `mode_out`, `cmd_pulse` and the status and event inputs.

Word map:
- word 0: mode
- word 1: command
- word 2: status
- word 3: interrupt flags
- word 4: interrupt enables

Top module: `can_ctl_regs`

## Requirements
- R1: After reset the mode word reads 0x1, the flag and enable words read 0, `mode_out` is 0x01, `cmd_pulse` is 0 and `irq` is low.
- R2: The mode word has these bits: bit0 reset-mode, bit1 listen-only, bit2 loopback, bit3 single-filter select and bit4 sleep. A mode write always updates bits 2:0. Bit0 = 1 selects `MODE_CFG` and bit0 = 0 selects `MODE_RUN`. The mode word and `mode_out` show the result from the cycle after the write.
- R3: Writes to mode bits 3 and 4 take effect only when the reset-mode bit is 1 at the time of the write. Otherwise those bits keep their value.
- R4: A write to word 1 drives `cmd_pulse` equal to the written bits 5:0 for exactly the one cycle after the write, and 0 otherwise. The command bits are: bit0 transmit, bit1 abort, bit2 release receive buffer, bit3 clear overrun, bit4 self-reception and bit5 bus-off. Word 1 always reads 0.
- R5: Word 2 reads the live status inputs with this layout:
  - `eng_status` in bits 7:0
  - `arb_lost_pos` in bits 12:8
  - `err_segment` in bits 20:16
  - `err_in_rx` in bit 21
  - `err_kind` in bits 23:22
  - all other bits 0
- R6: A 1 on `evt[i]` sets flag bit i of word 3. The flag stays set until it is cleared. The bits are: 0 receive valid, 1 transmit done, 2 error warning, 3 overrun, 4 wakeup, 5 error passive, 6 arbitration lost and 7 bus error.
- R7: Writing word 3 clears exactly the flags whose written bits are 1. Other flags are untouched.
- R8: If an event and a clear of the same flag occur in the same cycle, the flag ends set.
- R9: Word 4 is a read/write 8-bit enable register in bits 7:0.
- R10: `irq` is high exactly when some bit is set in both the flag word and the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Bus access strobe |
| reg_wr | input | 1 | Write when high, with reg_sel |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| eng_status | input | 8 | Engine status bits |
| err_kind | input | 2 | Last error type (0 bit, 1 form, 2 stuff, 3 other) |
| err_in_rx | input | 1 | Error occurred while receiving |
| err_segment | input | 5 | Frame segment code of the last error |
| arb_lost_pos | input | 5 | Bit position where arbitration was lost |
| evt | input | 8 | Interrupt event pulses |
| mode_out | output | 5 | Current mode bits to the engine |
| cmd_pulse | output | 6 | One-cycle command strobes |
| irq | output | 1 | Interrupt request |

## Verification
Writes and events register on the clock edge that samples them. Mode, flag and enable readback, `mode_out` and `irq` are therefore due one cycle after the stimulus. `cmd_pulse` is high during that same following cycle only, and must be 0 again one cycle later. Status readback and word reads are combinational, so they settle within the same cycle. The bench drives each stimulus across one rising edge, releases it just after that edge, and samples one time unit later. It then waits one more edge before checking that a command strobe has dropped.

// File: rtl/can_ctl_pkg.sv
package can_ctl_pkg;
    typedef enum logic {
        MODE_CFG = 1'b0,
        MODE_RUN = 1'b1
    } mode_state_e;

    localparam int WA_MODE   = 0;
    localparam int WA_CMD    = 1;
    localparam int WA_STATUS = 2;
    localparam int WA_FLAGS  = 3;
    localparam int WA_ENABLE = 4;

    localparam int MODE_W = 5;
    localparam int STAT_W = 24;
endpackage

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_val,
    output logic [MODE_W-1:0] mode_bits
);
    mode_state_e state_q, state_d;
    logic [1:0]  free_q;    // listen-only, loopback
    logic [1:0]  locked_q;  // filter select, sleep

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_CFG: if (wr_en && !wr_val[0]) state_d = MODE_RUN;  // GO_RUN
            MODE_RUN: if (wr_en &&  wr_val[0]) state_d = MODE_CFG;  // GO_CFG
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_CFG;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q   <= '0;
            locked_q <= '0;
        end else if (wr_en) begin
            free_q <= wr_val[2:1];
            if (state_q == MODE_CFG) locked_q <= wr_val[4:3];
        end
    end

    always_comb begin
        mode_bits = {locked_q, free_q, (state_q == MODE_CFG)};
    end
endmodule

// File: rtl/can_cmd_pulse.sv
module can_cmd_pulse #(
    parameter int CMD_N = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [CMD_N-1:0] val,
    output logic [CMD_N-1:0] pulse
);
    always_ff @(posedge clk) begin
        if (!rst_n)    pulse <= '0;
        else if (fire) pulse <= val;
        else           pulse <= '0;
    end
endmodule

// File: rtl/can_irq_bank.sv
module can_irq_bank #(
    parameter int IRQ_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] evt,
    input  logic             clr_en,
    input  logic [IRQ_N-1:0] clr_val,
    input  logic             en_wr,
    input  logic [IRQ_N-1:0] en_val,
    output logic [IRQ_N-1:0] flags,
    output logic [IRQ_N-1:0] enables,
    output logic             irq
);
    for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                      flags[i] <= 1'b0;
            else if (evt[i])                 flags[i] <= 1'b1;
            else if (clr_en && clr_val[i])   flags[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     enables <= '0;
        else if (en_wr) enables <= en_val;
    end

    assign irq = |(flags & enables);
endmodule

// File: rtl/can_ctl_regs.sv
module can_ctl_regs
    import can_ctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int IRQ_N  = 8,
    parameter int CMD_N  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [7:0]        eng_status,
    input  logic [1:0]        err_kind,
    input  logic              err_in_rx,
    input  logic [4:0]        err_segment,
    input  logic [4:0]        arb_lost_pos,
    input  logic [IRQ_N-1:0]  evt,
    output logic [MODE_W-1:0] mode_out,
    output logic [CMD_N-1:0]  cmd_pulse,
    output logic              irq
);
    logic              wr_any;
    logic              wr_mode, wr_cmd, wr_flags, wr_en;
    logic [IRQ_N-1:0]  flags, enables;
    logic [STAT_W-1:0] stat_word;
    logic              unused_wdata_hi;

    assign wr_any   = reg_sel && reg_wr;
    assign wr_mode  = wr_any && (reg_addr == ADDR_W'(WA_MODE));
    assign wr_cmd   = wr_any && (reg_addr == ADDR_W'(WA_CMD));
    assign wr_flags = wr_any && (reg_addr == ADDR_W'(WA_FLAGS));
    assign wr_en    = wr_any && (reg_addr == ADDR_W'(WA_ENABLE));
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:IRQ_N];

    can_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_mode),
        .wr_val(reg_wdata[MODE_W-1:0]), .mode_bits(mode_out)
    );

    can_cmd_pulse #(.CMD_N(CMD_N)) u_cmd (
        .clk(clk), .rst_n(rst_n), .fire(wr_cmd),
        .val(reg_wdata[CMD_N-1:0]), .pulse(cmd_pulse)
    );

    can_irq_bank #(.IRQ_N(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .clr_en(wr_flags), .clr_val(reg_wdata[IRQ_N-1:0]),
        .en_wr(wr_en), .en_val(reg_wdata[IRQ_N-1:0]),
        .flags(flags), .enables(enables), .irq(irq)
    );

    assign stat_word = {err_kind, err_in_rx, err_segment, 3'b000, arb_lost_pos, eng_status};

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(WA_MODE):   reg_rdata = DATA_W'(mode_out);
            ADDR_W'(WA_STATUS): reg_rdata = DATA_W'(stat_word);
            ADDR_W'(WA_FLAGS):  reg_rdata = DATA_W'(flags);
            ADDR_W'(WA_ENABLE): reg_rdata = DATA_W'(enables);
            default:            reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/can_ctl_regs_chk.sv
module can_ctl_regs_chk
    import can_ctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int IRQ_N  = 8,
    parameter int CMD_N  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [IRQ_N-1:0]  evt,
    input logic [MODE_W-1:0] mode_out,
    input logic [CMD_N-1:0]  cmd_pulse,
    input logic [IRQ_N-1:0]  flags,
    input logic [IRQ_N-1:0]  enables,
    input logic              irq
);
    p_cmd_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse != '0) |-> $past(reg_sel && reg_wr && reg_addr == ADDR_W'(WA_CMD)));

    p_cmd_val_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == ADDR_W'(WA_CMD)) |=> (cmd_pulse == $past(reg_wdata[CMD_N-1:0])));

    p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_out[0] |=> (mode_out[4:3] == $past(mode_out[4:3])));

    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    p_clear_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags) & ~flags) != '0) |-> $past(reg_sel && reg_wr && reg_addr == ADDR_W'(WA_FLAGS)));

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enables == '0) |-> !irq);
endmodule

bind can_ctl_regs can_ctl_regs_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_N(IRQ_N), .CMD_N(CMD_N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .evt(evt),
    .mode_out(mode_out), .cmd_pulse(cmd_pulse), .flags(flags),
    .enables(enables), .irq(irq)
);

// File: tb/tb_can_ctl_regs.sv
module tb_can_ctl_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_sel, reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [7:0]  eng_status;
    logic [1:0]  err_kind;
    logic        err_in_rx;
    logic [4:0]  err_segment, arb_lost_pos;
    logic [7:0]  evt;
    logic [4:0]  mode_out;
    logic [5:0]  cmd_pulse;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_status(eng_status), .err_kind(err_kind), .err_in_rx(err_in_rx),
        .err_segment(err_segment), .arb_lost_pos(arb_lost_pos), .evt(evt),
        .mode_out(mode_out), .cmd_pulse(cmd_pulse), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic fire_evt(input logic [7:0] v);
        @(negedge clk);
        evt = v;
        @(posedge clk); #1;
        evt = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  acc;
        rst_n = 1'b0; reg_sel = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        eng_status = 8'h3C; err_kind = 0; err_in_rx = 0; err_segment = 0;
        arb_lost_pos = 0; evt = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        rd(3'd0, d); check("R1 mode", d, 32'h1);
        rd(3'd3, d); check("R1 flags", d, 32'h0);
        rd(3'd4, d); check("R1 enables", d, 32'h0);
        check("R1 mode_out", {27'd0, mode_out}, 32'h1);
        check("R1 cmd_pulse", {26'd0, cmd_pulse}, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);

        // R2/R3 mode sweep from each state and locked-bit history
        for (int v = 0; v < 32; v++) begin
            wr(3'd0, 32'h1);
            wr(3'd0, v);
            rd(3'd0, d); check("R2 write from cfg", d, v);
            check("R2 mode_out", {27'd0, mode_out}, v);
            wr(3'd0, 32'h1);
            wr(3'd0, 32'h0);
            wr(3'd0, v);
            rd(3'd0, d); check("R3 run, locked clear", d, {27'd0, 2'b00, v[2:0]});
            wr(3'd0, 32'h19);
            wr(3'd0, 32'h18);
            wr(3'd0, v);
            rd(3'd0, d); check("R3 run, locked set", d, {27'd0, 2'b11, v[2:0]});
        end

        // R4 command sweep
        for (int v = 0; v < 64; v++) begin
            wr(3'd1, v);
            check("R4 pulse value", {26'd0, cmd_pulse}, v);
            rd(3'd1, d); check("R4 reads zero", d, 32'h0);
            @(posedge clk); #1;
            check("R4 pulse ends", {26'd0, cmd_pulse}, 32'h0);
        end

        // R5 status layout sweep
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 32; s += 5) begin
                err_kind = k[1:0]; err_in_rx = s[0]; err_segment = s[4:0];
                arb_lost_pos = 5'(31 - s); eng_status = 8'(s * 7 + k);
                rd(3'd2, d);
                check("R5 status", d, (k << 22) | ((s & 1) << 21) | (s << 16)
                      | ((31 - s) << 8) | ((s * 7 + k) & 8'hFF));
            end
        end

        // R6 sticky set, R7 exact clear
        wr(3'd3, 32'hFF);
        acc = '0;
        for (int i = 0; i < 8; i++) begin
            fire_evt(8'(1 << i));
            acc |= 8'(1 << i);
            @(posedge clk); #1;
            rd(3'd3, d); check("R6 flag sticky", d, {24'd0, acc});
        end
        wr(3'd3, 32'h55);
        rd(3'd3, d); check("R7 clear even", d, 32'hAA);
        wr(3'd3, 32'h0);
        rd(3'd3, d); check("R7 clear none", d, 32'hAA);
        wr(3'd3, 32'hFFFFFF82);
        rd(3'd3, d); check("R7 clear some", d, 32'h28);

        // R8 set wins over clear in the same cycle
        @(negedge clk);
        evt = 8'h10; reg_sel = 1; reg_wr = 1; reg_addr = 3'd3; reg_wdata = 32'h18;
        @(posedge clk); #1;
        evt = 0; reg_sel = 0; reg_wr = 0;
        rd(3'd3, d); check("R8 set wins", d, 32'h30);

        // R9/R10 enable vs flag sweep
        for (int f = 0; f < 256; f += 17) begin
            wr(3'd3, 32'hFF);
            fire_evt(8'(f));
            for (int e = 0; e < 256; e++) begin
                wr(3'd4, e);
                if (e % 51 == 0) begin
                    rd(3'd4, d); check("R9 enable readback", d, e);
                end
                check("R10 irq", {31'd0, irq}, {31'd0, ((f & e) != 0)});
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule